// File: doc/BRIEF.md
# Operand Shifter with Rotate-Through-Carry

This unit shapes the second operand of a data-processing operation before it reaches the arithmetic/logic stage. A 32-bit word is shifted or rotated by a type code and a 0 to 31 amount. The amount may come from an immediate field or a register, and this block does not care which. Alongside the word the unit produces a shifter carry. Flag logic downstream can use that carry in place of the ALU carry for logical operations.

Six operations are supported:
- left shift, logical or arithmetic, which behave the same
- right shift, logical or sign-filling
- rotate right
- a one-place rotate right through the carry flag

Every operation has a defined carry-out. When the amount is zero, the word passes through unchanged and the carry keeps its incoming value.

The unit takes one request per clock when `sh_valid` is high. It registers the shaped word and carry, so they appear one cycle later with `res_valid`. With no request the registered outputs hold. The block has no state machine. Its only state is the single result register.

Top module: `opsh_unit`

## Requirements
- R1: While `rst_n` is low, and after it, until the first accepted request, `res_valid`, `res_operand` and `res_carry` are all 0.
- R2: A request with `sh_valid` high at a rising edge is reflected at that edge: `res_valid` is 1 in the following cycle. A cycle with `sh_valid` low gives `res_valid` 0 and leaves `res_operand` and `res_carry` unchanged.
- R3: Kind 3'd0 (logical left) with amount n>0 gives `operand << n` with zeros shifted in, and carry = operand bit 32-n.
- R4: Kind 3'd2 (arithmetic left) gives exactly the result and carry of kind 3'd0 for every operand and amount.
- R5: Kind 3'd1 (logical right) with n>0 gives `operand >> n` with zeros shifted in, and carry = operand bit n-1.
- R6: Kind 3'd3 (arithmetic right) with n>0 copies operand bit 31 into the n vacated upper bits, and carry = operand bit n-1.
- R7: Kind 3'd4 (rotate right) with n>0 gives the operand rotated right by n (the amount is taken modulo 32), and carry = operand bit n-1, which equals result bit 31.
- R8: Kind 3'd5 (rotate right with extend) gives {carry_in, operand[31:1]} and carry = operand bit 0, whatever the amount.
- R9: For kinds 3'd0 to 3'd4 with amount 0, the result equals the operand and the carry equals `sh_carry`.
- R10: Kinds 3'd6 and 3'd7 are pass-through for any amount: the result equals the operand and the carry equals `sh_carry`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_valid | input | 1 | Request strobe |
| sh_operand | input | 32 | Operand to shape |
| sh_kind | input | 3 | Operation code (0 LSL, 1 LSR, 2 ASL, 3 ASR, 4 ROR, 5 RRX, 6/7 pass) |
| sh_amount | input | 5 | Shift or rotate amount, 0 to 31 |
| sh_carry | input | 1 | Incoming carry flag |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_operand | output | 32 | Shaped operand |
| res_carry | output | 1 | Shifter carry-out |

## Verification
The bench goes after amount zero, where a design that always reports a shifted-out bit would clobber the incoming carry. It also checks amount 31 on every kind, where an off-by-one in the carry index reads the wrong end of the word. It drives rotate-with-extend with nonzero amounts: a design that honoured the amount there would shift too far and lose the carry insertion at bit 31. It checks arithmetic right shift of negative words, where a zero fill would show up in the upper bits. It checks the unused codes, which a sloppy decoder would turn into a shift. Finally, it checks that idle cycles neither raise the valid flag nor disturb the held result.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
    localparam int unsigned OPSH_W = 32;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASL = 3'd2,
        SK_ASR = 3'd3,
        SK_ROR = 3'd4,
        SK_RRX = 3'd5
    } shift_kind_e;
endpackage

// File: rtl/opsh_rotr.sv
// Logarithmic right rotator: one conditional stage per amount bit.
module opsh_rotr #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [AW+1];

    assign stg[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][W-1:STEP]} : stg[s];
    end

    assign dout = stg[AW];
endmodule

// File: rtl/opsh_mask.sv
// Keep-mask for shifts: ones where rotated bits survive.
module opsh_mask #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0] amt,
    input  logic          to_left,
    output logic [W-1:0]  keep
);
    localparam logic [W-1:0] ONES = '1;

    always_comb begin
        if (to_left) keep = ONES << amt;
        else         keep = ONES >> amt;
    end
endmodule

// File: rtl/opsh_unit.sv
module opsh_unit
    import opsh_pkg::*;
#(
    parameter int unsigned W  = OPSH_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sh_valid,
    input  logic [W-1:0]  sh_operand,
    input  logic [2:0]    sh_kind,
    input  logic [AW-1:0] sh_amount,
    input  logic          sh_carry,
    output logic          res_valid,
    output logic [W-1:0]  res_operand,
    output logic          res_carry
);
    localparam logic [AW-1:0] AMT_ONE = AW'(1);

    logic          go_left;
    logic [AW-1:0] rot_amt;
    logic [W-1:0]  rotated;
    logic [W-1:0]  keep;
    logic [W-1:0]  fill;
    logic [AW-1:0] out_idx;
    logic          amt_zero;
    logic [W-1:0]  nxt_operand;
    logic          nxt_carry;

    assign go_left  = (sh_kind == SK_LSL) || (sh_kind == SK_ASL);
    // a left shift by n is a right rotate by W-n, masked
    assign rot_amt  = go_left ? (AW'(0) - sh_amount) : sh_amount;
    assign out_idx  = go_left ? rot_amt : (sh_amount - AMT_ONE);
    assign amt_zero = (sh_amount == '0);
    assign fill     = {W{sh_operand[W-1]}};

    opsh_rotr #(.W(W), .AW(AW)) u_rotr (
        .din  (sh_operand),
        .amt  (rot_amt),
        .dout (rotated)
    );

    opsh_mask #(.W(W), .AW(AW)) u_mask (
        .amt     (sh_amount),
        .to_left (go_left),
        .keep    (keep)
    );

    always_comb begin
        nxt_operand = sh_operand;
        nxt_carry   = sh_carry;
        unique case (sh_kind)
            SK_LSL, SK_ASL, SK_LSR: begin
                nxt_operand = rotated & keep;
                if (!amt_zero) nxt_carry = sh_operand[out_idx];
            end
            SK_ASR: begin
                nxt_operand = (rotated & keep) | (fill & ~keep);
                if (!amt_zero) nxt_carry = sh_operand[out_idx];
            end
            SK_ROR: begin
                nxt_operand = rotated;
                if (!amt_zero) nxt_carry = sh_operand[out_idx];
            end
            SK_RRX: begin
                nxt_operand = {sh_carry, sh_operand[W-1:1]};
                nxt_carry   = sh_operand[0];
            end
            default: begin
                nxt_operand = sh_operand;
                nxt_carry   = sh_carry;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_operand <= '0;
            res_carry   <= 1'b0;
        end else begin
            res_valid <= sh_valid;
            if (sh_valid) begin
                res_operand <= nxt_operand;
                res_carry   <= nxt_carry;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_valid |=> (!res_valid && $stable(res_operand) && $stable(res_carry)));

    // R9
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_amount == '0 && sh_kind <= 3'd4)
        |=> (res_operand == $past(sh_operand) && res_carry == $past(sh_carry)));

    // R8
    rrx_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind == 3'd5)
        |=> (res_operand[W-1] == $past(sh_carry) && res_carry == $past(sh_operand[0])));

    // R6
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind == 3'd3) |=> (res_operand[W-1] == $past(sh_operand[W-1])));

    // R3
    lsl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind == 3'd0 && sh_amount != '0) |=> (res_operand[0] == 1'b0));

    // R5
    lsr_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind == 3'd1 && sh_amount != '0) |=> (res_operand[W-1] == 1'b0));

    // R7
    ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind == 3'd4 && sh_amount != '0) |=> (res_carry == res_operand[W-1]));

    // R10
    spare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && sh_kind >= 3'd6)
        |=> (res_operand == $past(sh_operand) && res_carry == $past(sh_carry)));
endmodule

// File: tb/opsh_unit_test.sv
`timescale 1ns/1ps
module opsh_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sh_valid = 1'b0;
    logic [31:0] sh_operand = '0;
    logic [2:0]  sh_kind = '0;
    logic [4:0]  sh_amount = '0;
    logic        sh_carry = 1'b0;
    logic        res_valid;
    logic [31:0] res_operand;
    logic        res_carry;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    opsh_unit uut (
        .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_operand(sh_operand),
        .sh_kind(sh_kind), .sh_amount(sh_amount), .sh_carry(sh_carry),
        .res_valid(res_valid), .res_operand(res_operand), .res_carry(res_carry)
    );

    // {kind, amount, carry_in, operand, expected result, expected carry}
    localparam int NV = 16;
    localparam logic [73:0] VEC [NV] = '{
        {3'd0, 5'd4,  1'b0, 32'h8000_000F, 32'h0000_00F0, 1'b0},  // R3
        {3'd0, 5'd1,  1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1},  // R3
        {3'd0, 5'd31, 1'b0, 32'h0000_0003, 32'h8000_0000, 1'b1},  // R3
        {3'd2, 5'd1,  1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1},  // R4
        {3'd1, 5'd4,  1'b1, 32'h0000_00F8, 32'h0000_000F, 1'b1},  // R5
        {3'd1, 5'd31, 1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0},  // R5
        {3'd3, 5'd4,  1'b1, 32'h8000_0010, 32'hF800_0001, 1'b0},  // R6
        {3'd3, 5'd1,  1'b0, 32'h7FFF_FFFF, 32'h3FFF_FFFF, 1'b1},  // R6
        {3'd4, 5'd8,  1'b1, 32'h1234_5678, 32'h7812_3456, 1'b0},  // R7
        {3'd4, 5'd4,  1'b0, 32'h0000_000F, 32'hF000_0000, 1'b1},  // R7
        {3'd5, 5'd7,  1'b1, 32'h0000_0003, 32'h8000_0001, 1'b1},  // R8
        {3'd5, 5'd0,  1'b0, 32'h8000_0002, 32'h4000_0001, 1'b0},  // R8
        {3'd0, 5'd0,  1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},  // R9
        {3'd4, 5'd0,  1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0},  // R9
        {3'd6, 5'd9,  1'b1, 32'h1234_5678, 32'h1234_5678, 1'b1},  // R10
        {3'd7, 5'd31, 1'b0, 32'hFFFF_0000, 32'hFFFF_0000, 1'b0}   // R10
    };

    function automatic string req_of(input logic [2:0] k, input logic [4:0] a);
        if (k >= 3'd6) return "R10";
        if (k == 3'd5) return "R8";
        if (a == 5'd0) return "R9";
        case (k)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R4";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // independent bit-level model, returns {carry, result}
    function automatic logic [32:0] model(input logic [2:0] k, input logic [4:0] a,
                                          input logic ci, input logic [31:0] op);
        logic [31:0] r;
        logic c;
        int n;
        n = int'(a);
        r = op;
        c = ci;
        if (k == 3'd5) begin
            r = {ci, op[31:1]};
            c = op[0];
        end else if (k <= 3'd4 && n != 0) begin
            for (int i = 0; i < 32; i++) begin
                case (k)
                    3'd0, 3'd2: r[i] = (i >= n) ? op[i-n] : 1'b0;
                    3'd1:       r[i] = (i + n < 32) ? op[i+n] : 1'b0;
                    3'd3:       r[i] = (i + n < 32) ? op[i+n] : op[31];
                    default:    r[i] = op[(i + n) % 32];
                endcase
            end
            c = (k == 3'd0 || k == 3'd2) ? op[32-n] : op[n-1];
        end
        return {c, r};
    endfunction

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got carry=%0b value=%08h, expected carry=%0b value=%08h",
                     req, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic [4:0] a,
                         input logic ci, input logic [31:0] op);
        @(negedge clk);
        sh_valid = 1'b1; sh_kind = k; sh_amount = a; sh_carry = ci; sh_operand = op;
        @(negedge clk);
        sh_valid = 1'b0;
        check("R2", {32'd0, res_valid}, {32'd0, 1'b1});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [32:0] held;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", {res_operand, res_carry}, 33'd0);
        check("R1", {32'd0, res_valid}, 33'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after reset, no request yet
        check("R1", {res_operand, res_carry}, 33'd0);
        check("R1", {32'd0, res_valid}, 33'd0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][73:71], VEC[v][70:66], VEC[v][65], VEC[v][64:33]);
            check(req_of(VEC[v][73:71], VEC[v][70:66]),
                  {res_carry, res_operand}, {VEC[v][0], VEC[v][32:1]});
        end

        // R2: idle cycles hold the result while inputs wander
        apply(3'd3, 5'd2, 1'b1, 32'h8000_0004);
        held = {res_carry, res_operand};
        @(negedge clk);
        sh_kind = 3'd1; sh_amount = 5'd5; sh_operand = 32'h0F0F_0F0F; sh_carry = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", {res_carry, res_operand}, held);
        check("R2", {32'd0, res_valid}, 33'd0);

        // R8: amount ignored for extend-rotate
        for (int a = 0; a < 32; a += 5) begin
            apply(3'd5, 5'(a), 1'b0, 32'h0000_0005);
            check("R8", {res_carry, res_operand}, {1'b1, 32'h0000_0002});
        end

        // R4: arithmetic left matches logical left for every amount
        for (int a = 0; a < 32; a++) begin
            logic [32:0] lsl_out;
            apply(3'd0, 5'(a), a[1], 32'hB3C5_9A17);
            lsl_out = {res_carry, res_operand};
            apply(3'd2, 5'(a), a[1], 32'hB3C5_9A17);
            check("R4", {res_carry, res_operand}, lsl_out);
        end

        // Sweep of every kind and amount against the model
        for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < 32; a++) begin
                logic [31:0] op;
                op = 32'hC3A5_1E69 ^ (32'(a) * 32'h0101_0101) ^ (32'(k) << 28);
                apply(3'(k), 5'(a), a[0], op);
                check(req_of(3'(k), 5'(a)), {res_carry, res_operand},
                      model(3'(k), 5'(a), a[0], op));
            end
        end

        finish_run();
    end
endmodule